// File: doc/BRIEF.md
# Interrupt Enable and Pending Register Bank

This block keeps the per-line state of up to 64 external interrupt lines: an enable bit, a pending bit, an active bit and a priority value. Software reaches that state through a word-addressed register bus with byte strobes. Each enable and pending bit can be set or cleared through its own address, so changing one line leaves the others untouched. A trigger register pends one line, chosen by its number.

Level request inputs pend a line when they rise. From the enabled and pending lines, the block names the most urgent one to the core, together with a valid flag. The core confirms that it has taken the line with an acknowledge, and reports the end of a handler with a return strobe and the line number. These two strobes set and clear the active bits.

Top module: `irq_regbank`

## Requirements
- R1: Writing 1 to a bit of set-enable word k (word address 0x10+k) sets the enable of line 32k+bit. Writing 1 to the same bit of clear-enable word k (0x18+k) clears it. Writing 0 changes nothing, and both addresses read back the current enable bits.
- R2: Pending bits work the same way. Set-pending word k is at 0x20+k and clear-pending word k is at 0x28+k, and both read back the current pending bits.
- R3: Word k of every bit-per-line register holds lines 32k to 32k+31, with bit n for line 32k+n. Bits for lines that do not exist read as 0, and so do words that have no lines.
- R4: Priority word w (address 0x40+w) holds line 4w+j in byte j. Only the upper PRIO_BITS bits of each byte are stored and the lower bits read as 0, so writing 0xFF with PRIO_BITS=3 reads back 0xE0.
- R5: On every register, a write changes only the bytes whose strobe bit is set.
- R6: A write to the trigger register (0x01) with strobe bit 0 set pends the line whose number is in bits 8:0. A number of NUM_IRQ or more is ignored, and so is a write with strobe bit 0 clear.
- R7: The read-only type register (0x00) returns (NUM_IRQ-1)/32, which is 0 for 1 to 32 lines and 1 for 33 to 64 lines. Writes to it have no effect.
- R8: A rising edge on a request input pends its line in the next cycle. A request that stays high does not pend the line again after the pending bit has been cleared.
- R9: take_valid is high exactly when some line is both enabled and pending. take_id then names, among those lines, the one with the smallest priority value, with ties going to the lowest line number.
- R10: core_ack while take_valid is high clears the pending bit of take_id and sets its active bit on the same edge. A set event for that line in the same cycle keeps the pending bit set.
- R11: An active bit stays set until core_ret arrives with that line's ret_id, even while other lines are acknowledged. A ret_id of NUM_IRQ or more changes nothing, and writes to the active words (0x30+k) are ignored.
- R12: Reset clears all enable, pending, active and priority state, so take_valid is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_IRQ | Level interrupt requests, one per line |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Word address |
| bus_be | input | 4 | Byte strobes for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| take_valid | output | 1 | An enabled, pending line exists |
| take_id | output | 6 | Number of the winning line |
| core_ack | input | 1 | Core takes the line named by take_id |
| core_ret | input | 1 | Core finishes the handler of line ret_id |
| ret_id | input | 6 | Line whose handler returns |

## Verification
The assertions assume three things about the inputs: core_ack is only meaningful while take_valid is high, a line returns only after it has been acknowledged, and bus writes are the only way software changes the enable state. The stimulus follows these rules. It raises acknowledges only after it has seen take_valid high, it returns only lines it has acknowledged (apart from one deliberate out-of-range number), and it drives every input at the falling clock edge.

// File: rtl/irq_regbank_pkg.sv
package irq_regbank_pkg;
  localparam int MAX_IRQ    = 64;
  localparam int IRQ_ID_W   = 6;
  localparam int BUS_ADDR_W = 7;

  // Register groups, taken from bus_addr[6:3]
  localparam logic [3:0] GRP_CTRL   = 4'd0;
  localparam logic [3:0] GRP_EN_SET = 4'd2;
  localparam logic [3:0] GRP_EN_CLR = 4'd3;
  localparam logic [3:0] GRP_PD_SET = 4'd4;
  localparam logic [3:0] GRP_PD_CLR = 4'd5;
  localparam logic [3:0] GRP_ACT    = 4'd6;

  localparam logic [BUS_ADDR_W-1:0] ADDR_TYPE = 7'h00;
  localparam logic [BUS_ADDR_W-1:0] ADDR_TRIG = 7'h01;

  // Spread the four byte strobes into a 32-bit bit mask
  function automatic logic [31:0] strobe_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction

  // Place a stored priority of nbits bits at the top of a byte
  function automatic logic [7:0] prio_align(input logic [7:0] stored, input int nbits);
    return 8'(stored << (8 - nbits));
  endfunction
endpackage

// File: rtl/irq_line.sv
module irq_line #(
  parameter int PRIO_BITS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       en_set,
  input  logic       en_clr,
  input  logic       pd_set,
  input  logic       pd_clr,
  input  logic       prio_we,
  input  logic [7:0] prio_wbyte,
  input  logic       act_set,
  input  logic       act_clr,
  output logic       en,
  output logic       pend,
  output logic       act,
  output logic [7:0] prio
);
  import irq_regbank_pkg::*;

  logic                 req_q;
  logic [PRIO_BITS-1:0] prio_q;
  logic                 req_rise;

  assign req_rise = req & ~req_q;
  assign prio     = prio_align(8'(prio_q), PRIO_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      en     <= 1'b0;
      pend   <= 1'b0;
      act    <= 1'b0;
      prio_q <= '0;
    end else begin
      req_q <= req;
      if (en_set)      en <= 1'b1;
      else if (en_clr) en <= 1'b0;
      // a set event wins over a clear in the same cycle
      pend <= pd_set | req_rise | (pend & ~pd_clr);
      act  <= act_set | (act & ~act_clr);
      if (prio_we) prio_q <= prio_wbyte[7 -: PRIO_BITS];
    end
  end
endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode #(
  parameter int NUM_IRQ = 40
) (
  input  logic                                   bus_sel,
  input  logic                                   bus_wr,
  input  logic [irq_regbank_pkg::BUS_ADDR_W-1:0] bus_addr,
  input  logic [3:0]                             bus_be,
  input  logic [31:0]                            bus_wdata,
  output logic [NUM_IRQ-1:0]                     en_set,
  output logic [NUM_IRQ-1:0]                     en_clr,
  output logic [NUM_IRQ-1:0]                     pd_set,
  output logic [NUM_IRQ-1:0]                     pd_clr,
  output logic [NUM_IRQ-1:0]                     prio_we,
  output logic [NUM_IRQ-1:0][7:0]                prio_wbyte
);
  import irq_regbank_pkg::*;

  logic        wr;
  logic [3:0]  grp;
  logic [2:0]  widx;
  logic [31:0] bmask;
  logic        trig_ok;
  logic [8:0]  trig_num;

  assign wr       = bus_sel & bus_wr;
  assign grp      = bus_addr[6:3];
  assign widx     = bus_addr[2:0];
  assign bmask    = strobe_mask(bus_be);
  assign trig_ok  = wr && (bus_addr == ADDR_TRIG) && bus_be[0];
  assign trig_num = bus_wdata[8:0];

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    localparam int W  = i / 32;
    localparam int B  = i % 32;
    localparam int PW = i / 4;
    localparam int PB = i % 4;
    logic word_hit, bit_on;
    assign word_hit = (widx == 3'(W));
    assign bit_on   = bus_wdata[B] & bmask[B];
    assign en_set[i] = wr && (grp == GRP_EN_SET) && word_hit && bit_on;
    assign en_clr[i] = wr && (grp == GRP_EN_CLR) && word_hit && bit_on;
    assign pd_set[i] = (wr && (grp == GRP_PD_SET) && word_hit && bit_on)
                     || (trig_ok && (trig_num == 9'(i)));
    assign pd_clr[i] = wr && (grp == GRP_PD_CLR) && word_hit && bit_on;
    assign prio_we[i]    = wr && bus_addr[6] && (bus_addr[3:0] == 4'(PW)) && bus_be[PB];
    assign prio_wbyte[i] = bus_wdata[8*PB +: 8];
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_IRQ = 40
) (
  input  logic [NUM_IRQ-1:0]                       cand,
  input  logic [NUM_IRQ-1:0][7:0]                  prio,
  output logic                                     valid,
  output logic [irq_regbank_pkg::IRQ_ID_W-1:0]     id
);
  logic [7:0] best;

  // strict less-than keeps the lowest number on a tie
  always_comb begin
    valid = 1'b0;
    id    = '0;
    best  = 8'hFF;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand[i] && (!valid || (prio[i] < best))) begin
        valid = 1'b1;
        best  = prio[i];
        id    = irq_regbank_pkg::IRQ_ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank #(
  parameter int NUM_IRQ   = 40,
  parameter int PRIO_BITS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [6:0]         bus_addr,
  input  logic [3:0]         bus_be,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               take_valid,
  output logic [5:0]         take_id,
  input  logic               core_ack,
  input  logic               core_ret,
  input  logic [5:0]         ret_id
);
  import irq_regbank_pkg::*;

  localparam int NUM_WORDS = (NUM_IRQ + 31) / 32;
  localparam logic [31:0] TYPE_VAL = 32'(NUM_WORDS - 1);

  logic [NUM_IRQ-1:0]      en_set, en_clr, pd_set, pd_clr, prio_we;
  logic [NUM_IRQ-1:0][7:0] prio_wbyte;
  logic [NUM_IRQ-1:0]      en_vec, pd_vec, act_vec;
  logic [NUM_IRQ-1:0][7:0] prio_vec;
  logic [NUM_IRQ-1:0]      act_set, act_clr, pd_drop;
  logic                    ack_fire;
  logic [NUM_IRQ-1:0]      cand;

  assign ack_fire = core_ack & take_valid;
  assign cand     = en_vec & pd_vec;

  irq_bus_decode #(.NUM_IRQ(NUM_IRQ)) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .en_set(en_set), .en_clr(en_clr), .pd_set(pd_set),
    .pd_clr(pd_clr), .prio_we(prio_we), .prio_wbyte(prio_wbyte)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_ln
    assign act_set[i] = ack_fire && (take_id == 6'(i));
    assign act_clr[i] = core_ret && (ret_id == 6'(i));
    assign pd_drop[i] = pd_clr[i] | act_set[i];
    irq_line #(.PRIO_BITS(PRIO_BITS)) u_line (
      .clk(clk), .rst_n(rst_n), .req(irq_req[i]),
      .en_set(en_set[i]), .en_clr(en_clr[i]),
      .pd_set(pd_set[i]), .pd_clr(pd_drop[i]),
      .prio_we(prio_we[i]), .prio_wbyte(prio_wbyte[i]),
      .act_set(act_set[i]), .act_clr(act_clr[i]),
      .en(en_vec[i]), .pend(pd_vec[i]), .act(act_vec[i]), .prio(prio_vec[i])
    );
  end

  irq_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
    .cand(cand), .prio(prio_vec), .valid(take_valid), .id(take_id)
  );

  // Read path
  always_comb begin
    bus_rdata = '0;
    if (bus_addr[6]) begin
      for (int i = 0; i < NUM_IRQ; i++)
        if (4'(i / 4) == bus_addr[3:0]) bus_rdata[8*(i%4) +: 8] = prio_vec[i];
    end else begin
      unique case (bus_addr[6:3])
        GRP_CTRL:   if (bus_addr == ADDR_TYPE) bus_rdata = TYPE_VAL;
        GRP_EN_SET, GRP_EN_CLR:
          for (int i = 0; i < NUM_IRQ; i++)
            if (3'(i / 32) == bus_addr[2:0]) bus_rdata[i%32] = en_vec[i];
        GRP_PD_SET, GRP_PD_CLR:
          for (int i = 0; i < NUM_IRQ; i++)
            if (3'(i / 32) == bus_addr[2:0]) bus_rdata[i%32] = pd_vec[i];
        GRP_ACT:
          for (int i = 0; i < NUM_IRQ; i++)
            if (3'(i / 32) == bus_addr[2:0]) bus_rdata[i%32] = act_vec[i];
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_regbank_checker.sv
module irq_regbank_checker #(
  parameter int NUM_IRQ = 40
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [6:0]         bus_addr,
  input logic [31:0]        bus_rdata,
  input logic               take_valid,
  input logic [5:0]         take_id,
  input logic               core_ret,
  input logic               ack_fire,
  input logic [NUM_IRQ-1:0] en_vec,
  input logic [NUM_IRQ-1:0] pd_vec,
  input logic [NUM_IRQ-1:0] act_vec
);
  localparam logic [31:0] TYPE_EXP = 32'((NUM_IRQ - 1) / 32);

  p_enable_only_by_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> $stable(en_vec));

  p_type_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 7'h00) |-> bus_rdata == TYPE_EXP);

  p_winner_is_candidate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> (en_vec[take_id] && pd_vec[take_id]));

  p_idle_means_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !take_valid |-> ((en_vec & pd_vec) == '0));

  p_ack_sets_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> act_vec[$past(take_id)]);

  p_active_drops_on_return_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !core_ret |=> (($past(act_vec) & ~act_vec) == '0));
endmodule

bind irq_regbank irq_regbank_checker #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .take_valid(take_valid),
  .take_id(take_id), .core_ret(core_ret), .ack_fire(ack_fire),
  .en_vec(en_vec), .pd_vec(pd_vec), .act_vec(act_vec)
);

// File: tb/irq_regbank_bench.sv
module irq_regbank_bench;
  localparam int NIRQ = 40;
  localparam int NV   = 34;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NIRQ-1:0] irq_req = '0;
  logic            bus_sel = 1'b0, bus_wr = 1'b0;
  logic [6:0]      bus_addr = '0;
  logic [3:0]      bus_be = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            take_valid;
  logic [5:0]      take_id;
  logic            core_ack = 1'b0, core_ret = 1'b0;
  logic [5:0]      ret_id = '0;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  irq_regbank #(.NUM_IRQ(NIRQ), .PRIO_BITS(3)) u_irq_regbank (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .take_valid(take_valid), .take_id(take_id), .core_ack(core_ack),
    .core_ret(core_ret), .ret_id(ret_id)
  );

  // entry: {req tag[3:0], op[3:0] (1 write, 0 read), be[3:0], addr[7:0], data[31:0]}
  localparam logic [51:0] VEC [NV] = '{
    {4'd1, 4'd1, 4'hF, 8'h10, 32'h0000_00A5},  // R1 set enables
    {4'd1, 4'd0, 4'h0, 8'h10, 32'h0000_00A5},  // R1
    {4'd1, 4'd0, 4'h0, 8'h18, 32'h0000_00A5},  // R1 clear address reads state
    {4'd1, 4'd1, 4'hF, 8'h10, 32'h0000_0000},  // R1 zeros
    {4'd1, 4'd0, 4'h0, 8'h10, 32'h0000_00A5},  // R1
    {4'd1, 4'd1, 4'hF, 8'h18, 32'h0000_0005},  // R1 clear
    {4'd1, 4'd0, 4'h0, 8'h10, 32'h0000_00A0},  // R1
    {4'd3, 4'd1, 4'hF, 8'h11, 32'hFFFF_FFFF},  // R3 second word
    {4'd3, 4'd0, 4'h0, 8'h11, 32'h0000_00FF},  // R3 lines 32..39 only
    {4'd3, 4'd0, 4'h0, 8'h19, 32'h0000_00FF},  // R3
    {4'd5, 4'd1, 4'h2, 8'h10, 32'hFFFF_FFFF},  // R5 byte 1 only
    {4'd5, 4'd0, 4'h0, 8'h10, 32'h0000_FFA0},  // R5
    {4'd4, 4'd1, 4'h1, 8'h40, 32'h0000_00FF},  // R4
    {4'd4, 4'd0, 4'h0, 8'h40, 32'h0000_00E0},  // R4
    {4'd4, 4'd1, 4'hF, 8'h41, 32'h1234_5678},  // R4
    {4'd4, 4'd0, 4'h0, 8'h41, 32'h0020_4060},  // R4
    {4'd5, 4'd1, 4'hC, 8'h42, 32'hFFFF_FFFF},  // R5 upper bytes
    {4'd5, 4'd0, 4'h0, 8'h42, 32'hE0E0_0000},  // R5
    {4'd2, 4'd1, 4'hF, 8'h20, 32'h0000_0300},  // R2
    {4'd2, 4'd0, 4'h0, 8'h20, 32'h0000_0300},  // R2
    {4'd2, 4'd0, 4'h0, 8'h28, 32'h0000_0300},  // R2
    {4'd2, 4'd1, 4'hF, 8'h28, 32'h0000_0100},  // R2
    {4'd2, 4'd0, 4'h0, 8'h20, 32'h0000_0200},  // R2
    {4'd6, 4'd1, 4'h1, 8'h01, 32'h0000_0025},  // R6 line 37
    {4'd6, 4'd0, 4'h0, 8'h21, 32'h0000_0020},  // R6
    {4'd6, 4'd1, 4'h1, 8'h01, 32'h0000_0030},  // R6 line 48 absent
    {4'd6, 4'd0, 4'h0, 8'h21, 32'h0000_0020},  // R6
    {4'd6, 4'd1, 4'h2, 8'h01, 32'h0000_0003},  // R6 strobe 0 clear
    {4'd6, 4'd0, 4'h0, 8'h20, 32'h0000_0200},  // R6
    {4'd11, 4'd1, 4'hF, 8'h30, 32'hFFFF_FFFF}, // R11 active is read-only
    {4'd11, 4'd0, 4'h0, 8'h30, 32'h0000_0000}, // R11
    {4'd7, 4'd1, 4'hF, 8'h00, 32'hFFFF_FFFF},  // R7 read-only
    {4'd7, 4'd0, 4'h0, 8'h00, 32'h0000_0001},  // R7 40 lines
    {4'd3, 4'd0, 4'h0, 8'h12, 32'h0000_0000}   // R3 word without lines
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic read_check(input string tag, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(tag, d, exp);
  endtask

  task automatic win_check(input string tag, input logic v, input logic [5:0] id);
    @(negedge clk);
    #2;
    check({tag, " valid"}, 32'(take_valid), 32'(v));
    if (v) check({tag, " id"}, 32'(take_id), 32'(id));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();
    // R12 reset state
    win_check("R12", 1'b0, 6'd0);
    read_check("R12 enable", 7'h10, 32'h0);
    read_check("R12 prio", 7'h40, 32'h0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][47:44] == 4'd1)
        bus_write(VEC[v][38:32], VEC[v][43:40], VEC[v][31:0]);
      else begin
        bus_read(VEC[v][38:32], d);
        checks++;
        if (d !== VEC[v][31:0]) begin
          fails++;
          $display("FAIL R%0d vector %0d got=%h exp=%h", VEC[v][51:48], v, d, VEC[v][31:0]);
        end
      end
    end

    // arbitration and core handshake
    do_reset();
    bus_write(7'h40, 4'h8, 32'h4000_0000);  // line 3 -> 0x40
    bus_write(7'h41, 4'h2, 32'h0000_2000);  // line 5 -> 0x20
    bus_write(7'h42, 4'h2, 32'h0000_2000);  // line 9 -> 0x20
    bus_write(7'h48, 4'h8, 32'h2000_0000);  // line 35 -> 0x20
    bus_write(7'h10, 4'hF, 32'h0000_0228);
    bus_write(7'h11, 4'hF, 32'h0000_0008);
    @(negedge clk);
    irq_req[3] = 1'b1; irq_req[9] = 1'b1; irq_req[35] = 1'b1;
    win_check("R8 R9 lowest value", 1'b1, 6'd9);
    read_check("R8 edge pends", 7'h21, 32'h0000_0008);
    bus_write(7'h20, 4'hF, 32'h0000_0020);
    win_check("R9 tie lowest number", 1'b1, 6'd5);
    @(negedge clk); core_ack = 1'b1;
    @(negedge clk); core_ack = 1'b0;
    read_check("R10 active set", 7'h30, 32'h0000_0020);
    read_check("R10 pending cleared", 7'h20, 32'h0000_0208);
    win_check("R9 after ack", 1'b1, 6'd9);
    @(negedge clk); core_ack = 1'b1;
    @(negedge clk); core_ack = 1'b0;
    read_check("R11 both active", 7'h30, 32'h0000_0220);
    win_check("R9 second word wins", 1'b1, 6'd35);
    @(negedge clk); core_ret = 1'b1; ret_id = 6'd5;
    @(negedge clk); core_ret = 1'b0;
    read_check("R11 return", 7'h30, 32'h0000_0200);
    read_check("R8 held high no repend", 7'h20, 32'h0000_0008);
    bus_write(7'h19, 4'hF, 32'h0000_0008);
    win_check("R9 disabled line skipped", 1'b1, 6'd3);
    bus_write(7'h28, 4'hF, 32'h0000_0008);
    win_check("R9 none", 1'b0, 6'd0);
    @(negedge clk); irq_req[3] = 1'b0;
    bus_write(7'h20, 4'hF, 32'h0000_0008);
    win_check("R9 repend", 1'b1, 6'd3);
    @(negedge clk); core_ack = 1'b1; irq_req[3] = 1'b1;
    @(negedge clk); core_ack = 1'b0;
    read_check("R10 set wins over ack", 7'h20, 32'h0000_0008);
    read_check("R10 active on collision", 7'h30, 32'h0000_0208);
    @(negedge clk); core_ret = 1'b1; ret_id = 6'd50;
    @(negedge clk); core_ret = 1'b0;
    read_check("R11 bad ret_id", 7'h30, 32'h0000_0208);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule